// File: doc/BRIEF.md
# Double-Buffered Converter Control Core

This block sits between a serial front end and a 14-bit converter. It takes 16-bit command words, each qualified by a one-cycle strobe, and drives a two-stage data path. A staging register receives new codes. An output register holds the code the converter is currently showing. Commands can fill the staging register alone, copy it forward, or load both stages in the same cycle. The block also holds a user-controlled logic output and an output-mode bit that goes back to the serial front end.

Besides the command path, the block watches four pins through synchronizers: a lockout pin, a hardware power-down pin, an active-low clear and a clear-value select.
- Power-down can be entered only while the lockout pin is high.
- Power-down ends only on a lockout falling edge or on one of the two commands that move data into the output register.
- While powered down, both registers and the user output hold their values, so leaving power-down restores the previous code.
- A valid flag goes low during power-down and rises a programmable number of cycles after exit. This count stands for the analog settling time.

Top module: `dac_ctrl_core`

## Requirements
- R1: A strobed word with bits[15:14]=00 writes bits[13:0] into the staging register and leaves `code_out` unchanged.
- R2: A word with bits[15:14]=01 copies the staging register into the output register, so it appears on `code_out`.
- R3: A word with bits[15:14]=10 writes bits[13:0] into both the staging register and the output register in the same cycle.
- R4: A word with bits[15:12]=1110 sets `user_out` to bit[11].
- R5: A word with bits[15:12]=1111 sets the mode bit. Bit[11]=0 selects the alternate mode (`mode_alt`=1), and bit[11]=1 selects the default mode (`mode_alt`=0).
- R6: A word with bits[15:12]=1100 changes no output.
- R7: Power-down is entered by the word with bits[15:12]=1101, or by a rising edge on `pd_pin`. Either one takes effect only while `lockout` is high and is ignored while `lockout` is low.
- R8: Power-down ends only on a falling edge of `lockout` or on a word with bits[15:14]=01 or 10. Lowering `pd_pin` and writing the staging register do not end it.
- R9: During power-down `code_out` keeps its value. A lockout-edge exit keeps the same code, and a 01 exit shows the staging value written during power-down.
- R10: While `clr_n` is low, both registers load 0 if `rst_sel` is low or 8192 if it is high. `user_out` goes low, and strobed words are ignored.
- R11: During power-down `user_out` keeps its value, and words with bits[15:12]=1110 are ignored.
- R12: `out_valid` is low during power-down. After the exit edge it stays low for SETTLE_CYC-1 further edges and is high after the SETTLE_CYC-th.
- R13: After reset, `code_out`=0, `pd_flag`=0, `user_out`=0, `mode_alt`=0 and `out_valid`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_word | input | 16 | Command word from the serial front end |
| cmd_valid | input | 1 | One-cycle strobe qualifying `cmd_word` |
| lockout | input | 1 | Power-down permit; its falling edge ends power-down |
| pd_pin | input | 1 | Hardware power-down request (rising edge) |
| clr_n | input | 1 | Active-low clear |
| rst_sel | input | 1 | Clear value select: 0 gives code 0, 1 gives midscale |
| code_out | output | 14 | Output register code for the converter |
| pd_flag | output | 1 | High while powered down |
| user_out | output | 1 | User-programmable logic output |
| mode_alt | output | 1 | Output-mode bit returned to the serial front end |
| out_valid | output | 1 | Output settled and active |

## Verification
Command results are registered on the same rising edge that samples the strobe. The bench therefore queues each expectation just after that edge and compares it at the following falling edge. Pin effects pass through SYNC_STAGES synchronizer flops and one more register, so they are due after the third rising edge with the default of two stages. The pin task waits exactly that many edges before it queues its item. Valid-flag checks count edges from the exit edge: one check after SETTLE_CYC-1 edges expects the flag low, and the next edge expects it high.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

  // Decoded action for one command word; all fields zero when idle.
  typedef struct packed {
    logic ld_in;    // write staging register
    logic ld_dac;   // write output register with word data
    logic copy;     // move staging register into output register
    logic sw_pd;    // software power-down request
    logic upo_wr;   // user output write
    logic upo_val;
    logic mode_wr;  // output mode write
    logic mode_val; // 1 = alternate mode
  } dac_act_t;

  localparam int unsigned CMD_W = 16;

endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
  parameter int unsigned N         = 4,
  parameter int unsigned STAGES    = 2,
  parameter logic [N-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] pin_o
);

  logic [N-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RESET_VAL;
        else        stg_q[g] <= pin_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RESET_VAL;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign pin_o = stg_q[STAGES-1];

endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_ctrl_pkg::*;
(
  input  logic [CMD_W-1:0] word_i,
  input  logic             valid_i,
  output dac_act_t         act_o
);

  always_comb begin
    act_o = '0;
    if (valid_i) begin
      unique case (word_i[15:14])
        2'b00: act_o.ld_in = 1'b1;
        2'b01: act_o.copy  = 1'b1;
        2'b10: begin
          act_o.ld_in  = 1'b1;
          act_o.ld_dac = 1'b1;
        end
        default: begin
          unique case (word_i[13:12])
            2'b00: ;
            2'b01: act_o.sw_pd = 1'b1;
            2'b10: begin
              act_o.upo_wr  = 1'b1;
              act_o.upo_val = word_i[11];
            end
            default: begin
              act_o.mode_wr  = 1'b1;
              act_o.mode_val = ~word_i[11];
            end
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/dac_datapath.sv
module dac_datapath
  import dac_ctrl_pkg::*;
#(
  parameter int unsigned CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dac_act_t          act_i,
  input  logic [CODE_W-1:0] data_i,
  input  logic              clr_i,
  input  logic              rst_sel_i,
  output logic [CODE_W-1:0] code_o
);

  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] in_q, in_d, dac_q, dac_d, clr_val;
  logic              in_en, dac_en;

  assign clr_val = rst_sel_i ? MID_CODE : '0;

  always_comb begin
    in_en  = clr_i | act_i.ld_in;
    dac_en = clr_i | act_i.ld_dac | act_i.copy;
    in_d   = clr_i ? clr_val : data_i;
    if (clr_i)             dac_d = clr_val;
    else if (act_i.ld_dac) dac_d = data_i;
    else                   dac_d = in_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
    end else begin
      if (in_en)  in_q  <= in_d;
      if (dac_en) dac_q <= dac_d;
    end
  end

  assign code_o = dac_q;

  a_r2_copy: assert property (@(posedge clk) disable iff (!rst_n)
    act_i.copy |=> (code_o == $past(in_q)));

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (code_o == ($past(rst_sel_i) ? MID_CODE : '0)) && (in_q == code_o));

  a_r1_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !act_i.ld_dac && !act_i.copy) |=> $stable(code_o));

endmodule

// File: rtl/dac_power_ctrl.sv
module dac_power_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  dac_act_t act_i,
  input  logic     lock_i,
  input  logic     pd_pin_i,
  input  logic     clr_i,
  output logic     pd_o,
  output logic     upo_o,
  output logic     mode_o,
  output logic     valid_o
);

  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);

  logic          pd_q, pd_d, upo_q, upo_d, mode_q, mode_d;
  logic          lock_prev_q, pdpin_prev_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lock_fall, pd_rise, enter, leave, upo_en, mode_en;

  always_comb begin
    lock_fall = lock_prev_q & ~lock_i;
    pd_rise   = pd_pin_i & ~pdpin_prev_q;
    enter     = lock_i & (act_i.sw_pd | pd_rise);
    leave     = lock_fall | act_i.copy | act_i.ld_dac;

    if (leave)      pd_d = 1'b0;
    else if (enter) pd_d = 1'b1;
    else            pd_d = pd_q;

    upo_en = clr_i | (act_i.upo_wr & ~pd_q);
    upo_d  = clr_i ? 1'b0 : act_i.upo_val;

    mode_en = act_i.mode_wr;
    mode_d  = act_i.mode_val;

    if (pd_q && leave)  cnt_d = CW'(SETTLE_CYC);
    else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
    else                cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q         <= 1'b0;
      upo_q        <= 1'b0;
      mode_q       <= 1'b0;
      lock_prev_q  <= 1'b0;
      pdpin_prev_q <= 1'b0;
      cnt_q        <= '0;
    end else begin
      pd_q         <= pd_d;
      lock_prev_q  <= lock_i;
      pdpin_prev_q <= pd_pin_i;
      cnt_q        <= cnt_d;
      if (upo_en)  upo_q  <= upo_d;
      if (mode_en) mode_q <= mode_d;
    end
  end

  assign pd_o    = pd_q;
  assign upo_o   = upo_q;
  assign mode_o  = mode_q;
  assign valid_o = ~pd_q & (cnt_q == 0);

  a_r12_invalid_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
    pd_o |-> !valid_o);

  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_o && !lock_i) |=> !pd_o);

  a_r8_stay: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_o && lock_i && !act_i.copy && !act_i.ld_dac) |=> pd_o);

  a_r11_upo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_o && !clr_i) |=> $stable(upo_o));

  a_r12_settle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_o && !pd_d) |=> !valid_o);

endmodule

// File: rtl/dac_ctrl_core.sv
module dac_ctrl_core
  import dac_ctrl_pkg::*;
#(
  parameter int unsigned CODE_W      = 14,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SETTLE_CYC  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              cmd_valid,
  input  logic              lockout,
  input  logic              pd_pin,
  input  logic              clr_n,
  input  logic              rst_sel,
  output logic [CODE_W-1:0] code_out,
  output logic              pd_flag,
  output logic              user_out,
  output logic              mode_alt,
  output logic              out_valid
);

  localparam int unsigned NPIN = 4;

  logic [1:0]      rst_pipe_q;
  logic            rst_i_n;
  logic [NPIN-1:0] pins_s;
  logic            lock_s, pdpin_s, clr_s, sel_s;
  dac_act_t        act_raw, act_g;

  // Reset: asserted asynchronously, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i_n = rst_pipe_q[1];

  dac_pin_sync #(
    .N(NPIN), .STAGES(SYNC_STAGES), .RESET_VAL(4'b0100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .pin_i ({rst_sel, clr_n, pd_pin, lockout}),
    .pin_o (pins_s)
  );

  assign lock_s  = pins_s[0];
  assign pdpin_s = pins_s[1];
  assign clr_s   = ~pins_s[2];
  assign sel_s   = pins_s[3];

  dac_cmd_decode u_dec (
    .word_i  (cmd_word),
    .valid_i (cmd_valid),
    .act_o   (act_raw)
  );

  // Clear overrides every command while it is held.
  assign act_g = clr_s ? '0 : act_raw;

  dac_datapath #(.CODE_W(CODE_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .act_i     (act_g),
    .data_i    (cmd_word[CODE_W-1:0]),
    .clr_i     (clr_s),
    .rst_sel_i (sel_s),
    .code_o    (code_out)
  );

  dac_power_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_pwr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .act_i    (act_g),
    .lock_i   (lock_s),
    .pd_pin_i (pdpin_s),
    .clr_i    (clr_s),
    .pd_o     (pd_flag),
    .upo_o    (user_out),
    .mode_o   (mode_alt),
    .valid_o  (out_valid)
  );

  a_r10_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_i_n)
    clr_s |=> (user_out == 1'b0));

  a_r9_code_frozen: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pd_flag && !clr_s && !(cmd_valid && cmd_word[15:14] != 2'b00 && cmd_word[15:14] != 2'b11))
      |=> $stable(code_out));

endmodule

// File: tb/sim_dac_ctrl_core.sv
module sim_dac_ctrl_core;

  localparam int unsigned SETTLE = 8;
  localparam int unsigned LAT    = 3;  // SYNC_STAGES + 1

  logic        clk, rst_n;
  logic [15:0] cmd_word;
  logic        cmd_valid, lockout, pd_pin, clr_n, rst_sel;
  logic [13:0] code_out;
  logic        pd_flag, user_out, mode_alt, out_valid;

  int checks = 0;
  int fails  = 0;
  logic  done = 1'b0;
  logic [17:0] exp_q[$];
  string       req_q[$];

  dac_ctrl_core #(.CODE_W(14), .SYNC_STAGES(2), .SETTLE_CYC(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_valid(cmd_valid),
    .lockout(lockout), .pd_pin(pd_pin), .clr_n(clr_n), .rst_sel(rst_sel),
    .code_out(code_out), .pd_flag(pd_flag), .user_out(user_out),
    .mode_alt(mode_alt), .out_valid(out_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Scoreboard: expectation pushed just after the due edge.
  task automatic expect_st(input logic [13:0] c, input logic pd, input logic u,
                           input logic m, input logic v, input string r);
    exp_q.push_back({c, pd, u, m, v});
    req_q.push_back(r);
  endtask

  // Monitor: compares at the falling edge.
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      logic [17:0] e, a;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      a = {code_out, pd_flag, user_out, mode_alt, out_valid};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: actual code=%0d pd=%b upo=%b mode=%b valid=%b expected code=%0d pd=%b upo=%b mode=%b valid=%b",
                 r, a[17:4], a[3], a[2], a[1], a[0], e[17:4], e[3], e[2], e[1], e[0]);
      end
    end
  end

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    cmd_word  = w;
    cmd_valid = 1'b1;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
  endtask

  task automatic pins(input logic lk, input logic pd, input logic cl, input logic rs);
    @(negedge clk);
    lockout = lk; pd_pin = pd; clr_n = cl; rst_sel = rs;
    repeat (LAT) @(posedge clk);
    #1;
  endtask

  task automatic settle(input logic [13:0] c, input logic u, input logic m, input string r);
    repeat (SETTLE - 1) @(posedge clk);
    #1;
    expect_st(c, 1'b0, u, m, 1'b0, r);
    @(posedge clk);
    #1;
    expect_st(c, 1'b0, u, m, 1'b1, r);
  endtask

  initial begin
    rst_n = 1'b0; cmd_word = '0; cmd_valid = 1'b0;
    lockout = 1'b1; pd_pin = 1'b0; clr_n = 1'b1; rst_sel = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    expect_st(14'd0, 0, 0, 0, 1, "R13 reset");

    send(16'h1234);                       // 00: staging only
    expect_st(14'd0, 0, 0, 0, 1, "R1 load staging");
    send(16'h4000);                       // 01: copy
    expect_st(14'h1234, 0, 0, 0, 1, "R2 copy");
    send({2'b10, 14'h3FFF});
    expect_st(14'h3FFF, 0, 0, 0, 1, "R3 load both");
    send({2'b00, 14'h0555});
    expect_st(14'h3FFF, 0, 0, 0, 1, "R1 staging only");
    send(16'hC000);                       // nop
    expect_st(14'h3FFF, 0, 0, 0, 1, "R6 nop");

    send(16'hE800);
    expect_st(14'h3FFF, 0, 1, 0, 1, "R4 user high");
    send(16'hE000);
    expect_st(14'h3FFF, 0, 0, 0, 1, "R4 user low");
    send(16'hE800);
    expect_st(14'h3FFF, 0, 1, 0, 1, "R4 user high again");

    send(16'hF000);
    expect_st(14'h3FFF, 0, 1, 1, 1, "R5 alternate mode");
    send(16'hF800);
    expect_st(14'h3FFF, 0, 1, 0, 1, "R5 default mode");
    send(16'hF000);
    expect_st(14'h3FFF, 0, 1, 1, 1, "R5 alternate mode again");

    send(16'h4000);                       // copy staging 0555
    expect_st(14'h0555, 0, 1, 1, 1, "R2 copy second");

    // Lockout low: requests ignored.
    pins(0, 0, 1, 0);
    send(16'hD000);
    expect_st(14'h0555, 0, 1, 1, 1, "R7 sw request ignored");
    pins(0, 1, 1, 0);
    expect_st(14'h0555, 0, 1, 1, 1, "R7 hw request ignored");
    pins(0, 0, 1, 0);
    pins(1, 0, 1, 0);

    // Software power-down.
    send(16'hD000);
    expect_st(14'h0555, 1, 1, 1, 0, "R7 sw power-down");
    send(16'hE000);
    expect_st(14'h0555, 1, 1, 1, 0, "R11 user write ignored");
    send({2'b00, 14'h0AAA});
    expect_st(14'h0555, 1, 1, 1, 0, "R8 staging write keeps power-down");
    send(16'h4000);
    expect_st(14'h0AAA, 0, 1, 1, 0, "R9 exit via copy");
    settle(14'h0AAA, 1, 1, "R12 settle after copy exit");

    // Hardware power-down, pin low does not exit, lockout edge does.
    pins(1, 1, 1, 0);
    expect_st(14'h0AAA, 1, 1, 1, 0, "R7 hw power-down");
    pins(1, 0, 1, 0);
    expect_st(14'h0AAA, 1, 1, 1, 0, "R8 pin low stays");
    pins(0, 0, 1, 0);
    expect_st(14'h0AAA, 0, 1, 1, 0, "R9 lockout exit keeps code");
    settle(14'h0AAA, 1, 1, "R12 settle after lockout exit");
    pins(1, 0, 1, 0);

    send(16'hD000);
    expect_st(14'h0AAA, 1, 1, 1, 0, "R7 sw power-down again");
    send({2'b10, 14'h0777});
    expect_st(14'h0777, 0, 1, 1, 0, "R8 exit via load both");
    settle(14'h0777, 1, 1, "R12 settle after load exit");

    // Clear to midscale, commands ignored, staging also cleared.
    pins(1, 0, 0, 1);
    expect_st(14'd8192, 0, 0, 1, 1, "R10 clear midscale");
    send({2'b10, 14'h0001});
    expect_st(14'd8192, 0, 0, 1, 1, "R10 command ignored in clear");
    pins(1, 0, 1, 1);
    send(16'h4000);
    expect_st(14'd8192, 0, 0, 1, 1, "R10 staging holds clear value");
    pins(1, 0, 0, 0);
    expect_st(14'd0, 0, 0, 1, 1, "R10 clear zero");
    pins(1, 0, 1, 0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule